// File: doc/BRIEF.md
# Copy-Engine Channel Register Bank

This block is the memory-mapped register front end of a descriptor-chained copy engine. A simple request strobe carries one access per cycle: valid, write flag, size code, byte address and 64-bit data. The block decodes the address into a device-global window or one of several per-channel windows, checks the access size against the register it reaches, and updates or returns the register contents. It answers one cycle later with a response strobe, read data and an error flag. A bad address or a bad size is reported on the response and never stalls.

Each channel holds a control word, a status word, a descriptor-chain pointer, a completion pointer, the last command byte and a sticky error word. A command write gives a one-cycle start, append or reset pulse to that channel's sequencer. The sequencer sends back a per-channel busy level and a strobe that records the last completed descriptor. The status read merges a live idle indication into bit 0.

Top module: `chan_reg_file`

## Requirements
- R1: Address bits [ADDR_W-1:7] select a 128-byte window. Window 0 is global, and its only register is a read-only byte at offset 0x00 that returns NCH. Window k (k ≥ 1) is channel k-1. A window above NCH gives rspErr=1 with rspRdata=0 and changes no state.
- R2: rspValid is high exactly in the cycle after reqValid and is low otherwise. A write returns rspRdata=0.
- R3: The control register at channel offset 0x00 is 16 bits (size code 1) and resets to 0x0001. A write loads bits 15:1 from the data. Writing 1 to bit 0 clears it and writing 0 leaves it unchanged.
- R4: The status register at offset 0x08 is 64 bits (size code 3). It reads as {descriptor index in bits 63:6, 3'b000, transfer status in bits 2:0}, with bit 0 OR-ed with "channel not busy". Writes are accepted without error and change nothing. The transfer status resets to 3.
- R5: A complValid[c] strobe loads complDescIdx into status bits 63:6 of channel c.
- R6: The chain pointer takes a 64-bit write (size 3) or a 32-bit write (size 2) of its low half at offset 0x10, and a 32-bit access of its high half at offset 0x14. A partial write keeps the other half, and a 32-bit read returns that half zero-extended.
- R7: The completion pointer behaves the same way at offsets 0x20 (low or full) and 0x24 (high).
- R8: The command byte at offset 0x18 (size 0) decodes bit 0 start, bit 1 append and bit 5 reset, with priority start > append > reset. The winning command gives a one-cycle pulse on that channel's line in the same cycle as rspValid. Start sets the transfer status to 0 and reset sets it to 3. A read returns the last byte written.
- R9: A command byte with none of bits 0, 1 or 5 set but any of bits 4:2 set raises no pulse and sets sticky error bit 0 of the channel.
- R10: The error word at offset 0x28 is 32 bits (size 2) and resets to 0. Each data bit written as 1 clears the matching error bit.
- R11: An access with a size code the register does not allow gives rspErr=1 and rspRdata=0, changes no register and sets error bit 1 of that channel.
- R12: An unmapped offset in a channel window gives rspErr=1, rspRdata=0 and sets that channel's error bit 1. An unmapped offset or wrong size in the global window only gives rspErr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 64 | Write data, right-justified |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspErr | output | 1 | Access error for this response |
| rspRdata | output | 64 | Read data, right-justified |
| startPulse | output | NCH | Per-channel start pulse |
| appendPulse | output | NCH | Per-channel append pulse |
| resetPulse | output | NCH | Per-channel reset pulse |
| chanBusy | input | NCH | Per-channel busy level from the sequencer |
| complValid | input | NCH | Per-channel completed-descriptor strobe |
| complDescIdx | input | 58 | Completed descriptor address in 64-byte units |

## Verification
The properties assume that at most one request is presented per cycle and that reqWrite and reqAddr are stable whenever reqValid is high. The response and pulse checks rely on this to link each response to the request of the cycle before. The stimulus keeps to it by raising reqValid for one cycle per access, always from the falling edge. It leaves at least one idle cycle between accesses, so the quiet-response property is exercised as well. Busy and completion inputs change only when no access to the same channel is in flight.

// File: rtl/chan_reg_pkg.sv
`timescale 1ns/1ps
package chan_reg_pkg;
  localparam int IDX_W = 6;  // up to 64 channels

  typedef enum logic [3:0] {
    SEL_NONE, SEL_GCOUNT, SEL_CTRL, SEL_STATUS, SEL_CHAIN_LO, SEL_CHAIN_HI,
    SEL_CMD, SEL_COMPL_LO, SEL_COMPL_HI, SEL_ERR
  } regSel_e;

  // strobes passed from the decoder to the register datapath
  typedef struct packed {
    logic             isChan;  // address lands in a configured channel window
    logic             wrEn;
    logic             rdEn;
    logic             full;    // 64-bit access
    logic             accErr;  // channel-window access fault (size/offset)
    logic             decErr;  // global or out-of-range fault
    regSel_e          sel;
    logic [IDX_W-1:0] chan;
  } regStrobe_t;
endpackage

// File: rtl/chan_reg_decode.sv
`timescale 1ns/1ps
module chan_reg_decode
  import chan_reg_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 13
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output regStrobe_t        strobe
);
  localparam int WIN_W = ADDR_W - 7;

  logic [WIN_W-1:0] win;
  logic [6:0]       offs;
  logic             inRange;
  regSel_e          sel;
  logic             sizeOk;

  assign win     = reqAddr[ADDR_W-1:7];
  assign offs    = reqAddr[6:0];
  assign inRange = (win != '0) && (int'(win) <= NCH);

  always_comb begin
    sel    = SEL_NONE;
    sizeOk = 1'b0;
    if (win == '0) begin
      if (offs == 7'h00) begin sel = SEL_GCOUNT; sizeOk = (reqSize == 2'd0); end
    end else begin
      case (offs)
        7'h00: begin sel = SEL_CTRL;     sizeOk = (reqSize == 2'd1); end
        7'h08: begin sel = SEL_STATUS;   sizeOk = (reqSize == 2'd3); end
        7'h10: begin sel = SEL_CHAIN_LO; sizeOk = reqSize[1]; end
        7'h14: begin sel = SEL_CHAIN_HI; sizeOk = (reqSize == 2'd2); end
        7'h18: begin sel = SEL_CMD;      sizeOk = (reqSize == 2'd0); end
        7'h20: begin sel = SEL_COMPL_LO; sizeOk = reqSize[1]; end
        7'h24: begin sel = SEL_COMPL_HI; sizeOk = (reqSize == 2'd2); end
        7'h28: begin sel = SEL_ERR;      sizeOk = (reqSize == 2'd2); end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.sel    = sel;
    strobe.isChan = inRange;
    strobe.chan   = IDX_W'(int'(win) - 1);
    strobe.wrEn   = reqValid & reqWrite;
    strobe.rdEn   = reqValid & ~reqWrite;
    strobe.full   = (reqSize == 2'd3);
    strobe.accErr = inRange & ((sel == SEL_NONE) | ~sizeOk);
    strobe.decErr = ~inRange & ((win != '0) | (sel == SEL_NONE) | ~sizeOk);
  end
endmodule

// File: rtl/chan_reg_bank.sv
`timescale 1ns/1ps
module chan_reg_bank
  import chan_reg_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  regStrobe_t      strobe,
  input  logic [63:0]     wdata,
  input  logic [NCH-1:0]  chanBusy,
  input  logic [NCH-1:0]  complValid,
  input  logic [57:0]     complDescIdx,
  output logic            rspValid,
  output logic            rspErr,
  output logic [63:0]     rspRdata,
  output logic [NCH-1:0]  startPulse,
  output logic [NCH-1:0]  appendPulse,
  output logic [NCH-1:0]  resetPulse
);
  localparam logic [7:0] CHAN_COUNT = 8'(NCH);

  logic [63:0]    chRd [NCH];
  logic [NCH-1:0] startD, appendD, resetD;
  logic [63:0]    rdMux, rdData;
  logic           cmdStart, cmdAppend, cmdReset, cmdOther;

  // command priority: start > append > reset
  assign cmdStart  = wdata[0];
  assign cmdAppend = ~wdata[0] & wdata[1];
  assign cmdReset  = ~wdata[0] & ~wdata[1] & wdata[5];
  assign cmdOther  = ~(wdata[0] | wdata[1] | wdata[5]) & (|wdata[4:2]);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic        chHit, wrOk;
    logic [15:0] ctrlQ;
    logic [2:0]  xferQ;
    logic [57:0] descQ;
    logic [63:0] chainQ, complQ;
    logic [7:0]  cmdQ;
    logic [31:0] errQ;

    assign chHit = reqValid & strobe.isChan & (strobe.chan == IDX_W'(c));
    assign wrOk  = chHit & strobe.wrEn & ~strobe.accErr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ  <= 16'h0001;
        xferQ  <= 3'd3;
        descQ  <= '0;
        chainQ <= '0;
        complQ <= '0;
        cmdQ   <= '0;
      end else begin
        if (wrOk) begin
          case (strobe.sel)
            SEL_CTRL:     ctrlQ  <= {wdata[15:1], ctrlQ[0] & ~wdata[0]};
            SEL_CHAIN_LO: chainQ <= strobe.full ? wdata : {chainQ[63:32], wdata[31:0]};
            SEL_CHAIN_HI: chainQ <= {wdata[31:0], chainQ[31:0]};
            SEL_COMPL_LO: complQ <= strobe.full ? wdata : {complQ[63:32], wdata[31:0]};
            SEL_COMPL_HI: complQ <= {wdata[31:0], complQ[31:0]};
            SEL_CMD: begin
              cmdQ <= wdata[7:0];
              if (cmdStart)      xferQ <= 3'd0;
              else if (cmdReset) xferQ <= 3'd3;
            end
            default: ;
          endcase
        end
        if (complValid[c]) descQ <= complDescIdx;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errQ <= '0;
      else if (wrOk && strobe.sel == SEL_ERR) errQ <= errQ & ~wdata[31:0];
      else begin
        if (chHit && strobe.accErr) errQ[1] <= 1'b1;
        if (wrOk && strobe.sel == SEL_CMD && cmdOther) errQ[0] <= 1'b1;
      end
    end

    assign startD[c]  = wrOk && strobe.sel == SEL_CMD && cmdStart;
    assign appendD[c] = wrOk && strobe.sel == SEL_CMD && cmdAppend;
    assign resetD[c]  = wrOk && strobe.sel == SEL_CMD && cmdReset;

    always_comb begin
      case (strobe.sel)
        SEL_CTRL:     chRd[c] = {48'h0, ctrlQ};
        SEL_STATUS:   chRd[c] = {descQ, 3'b000, xferQ[2:1], xferQ[0] | ~chanBusy[c]};
        SEL_CHAIN_LO: chRd[c] = strobe.full ? chainQ : {32'h0, chainQ[31:0]};
        SEL_CHAIN_HI: chRd[c] = {32'h0, chainQ[63:32]};
        SEL_CMD:      chRd[c] = {56'h0, cmdQ};
        SEL_COMPL_LO: chRd[c] = strobe.full ? complQ : {32'h0, complQ[31:0]};
        SEL_COMPL_HI: chRd[c] = {32'h0, complQ[63:32]};
        SEL_ERR:      chRd[c] = {32'h0, errQ};
        default:      chRd[c] = '0;
      endcase
    end
  end

  always_comb begin
    rdMux = '0;
    if (strobe.sel == SEL_GCOUNT) rdMux = {56'h0, CHAN_COUNT};
    for (int c = 0; c < NCH; c++)
      if (strobe.isChan && strobe.chan == IDX_W'(c)) rdMux = chRd[c];
    rdData = (strobe.rdEn & ~strobe.accErr & ~strobe.decErr) ? rdMux : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspErr      <= 1'b0;
      rspRdata    <= '0;
      startPulse  <= '0;
      appendPulse <= '0;
      resetPulse  <= '0;
    end else begin
      rspValid    <= reqValid;
      rspErr      <= reqValid & (strobe.accErr | strobe.decErr);
      rspRdata    <= rdData;
      startPulse  <= startD;
      appendPulse <= appendD;
      resetPulse  <= resetD;
    end
  end
endmodule

// File: rtl/chan_reg_file.sv
`timescale 1ns/1ps
module chan_reg_file
  import chan_reg_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [63:0]       rspRdata,
  output logic [NCH-1:0]    startPulse,
  output logic [NCH-1:0]    appendPulse,
  output logic [NCH-1:0]    resetPulse,
  input  logic [NCH-1:0]    chanBusy,
  input  logic [NCH-1:0]    complValid,
  input  logic [57:0]       complDescIdx
);
  regStrobe_t strobe;

  chan_reg_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .strobe(strobe)
  );

  chan_reg_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .strobe(strobe),
    .wdata(reqWdata), .chanBusy(chanBusy), .complValid(complValid),
    .complDescIdx(complDescIdx), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .startPulse(startPulse), .appendPulse(appendPulse),
    .resetPulse(resetPulse)
  );
endmodule

// File: rtl/chan_reg_file_chk.sv
`timescale 1ns/1ps
module chan_reg_file_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspErr,
  input logic [63:0]       rspRdata,
  input logic [NCH-1:0]    startPulse,
  input logic [NCH-1:0]    appendPulse,
  input logic [NCH-1:0]    resetPulse
);
  logic beyondChan;
  logic anyPulse;
  assign beyondChan = int'(reqAddr[ADDR_W-1:7]) > NCH;
  assign anyPulse   = |(startPulse | appendPulse | resetPulse);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspErr));
  p_write_no_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqWrite)) |-> (rspRdata == 64'h0));
  p_err_zero_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == 64'h0));
  p_bad_chan_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && beyondChan) |=> rspErr);
  p_pulse_from_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |-> (rspValid && !rspErr && $past(reqWrite)));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, appendPulse, resetPulse}));
endmodule

bind chan_reg_file chan_reg_file_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .rspValid(rspValid), .rspErr(rspErr),
  .rspRdata(rspRdata), .startPulse(startPulse), .appendPulse(appendPulse),
  .resetPulse(resetPulse)
);

// File: tb/chan_reg_file_bench.sv
`timescale 1ns/1ps
module chan_reg_file_bench;
  localparam int NCH = 4;
  localparam int AW  = 13;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [12:0] addr;
    logic [63:0] wd;
    logic [63:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 13'h000, 64'h0, 64'h4, 1'b0, 4'd1},                  // R1 count
    '{1'b0, 2'd1, 13'h100, 64'h0, 64'h1, 1'b0, 4'd3},                  // R3 reset value
    '{1'b1, 2'd1, 13'h100, 64'hABCE, 64'h0, 1'b0, 4'd3},
    '{1'b0, 2'd1, 13'h100, 64'h0, 64'hABCF, 1'b0, 4'd3},               // R3 bit0 kept
    '{1'b1, 2'd1, 13'h100, 64'h1235, 64'h0, 1'b0, 4'd3},
    '{1'b0, 2'd1, 13'h100, 64'h0, 64'h1234, 1'b0, 4'd3},               // R3 bit0 cleared
    '{1'b0, 2'd3, 13'h108, 64'h0, 64'h3, 1'b0, 4'd4},                  // R4 halted+idle
    '{1'b1, 2'd3, 13'h108, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 4'd4},
    '{1'b0, 2'd3, 13'h108, 64'h0, 64'h3, 1'b0, 4'd4},                  // R4 write ignored
    '{1'b1, 2'd3, 13'h110, 64'h1111_2222_3333_4444, 64'h0, 1'b0, 4'd6},
    '{1'b1, 2'd2, 13'h110, 64'hAAAA_BBBB, 64'h0, 1'b0, 4'd6},
    '{1'b0, 2'd3, 13'h110, 64'h0, 64'h1111_2222_AAAA_BBBB, 1'b0, 4'd6}, // R6
    '{1'b1, 2'd2, 13'h114, 64'hCCCC_DDDD, 64'h0, 1'b0, 4'd6},
    '{1'b0, 2'd3, 13'h110, 64'h0, 64'hCCCC_DDDD_AAAA_BBBB, 1'b0, 4'd6},
    '{1'b0, 2'd2, 13'h114, 64'h0, 64'hCCCC_DDDD, 1'b0, 4'd6},
    '{1'b0, 2'd2, 13'h110, 64'h0, 64'hAAAA_BBBB, 1'b0, 4'd6},
    '{1'b1, 2'd3, 13'h120, 64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, 4'd7},
    '{1'b1, 2'd2, 13'h124, 64'h5555_6666, 64'h0, 1'b0, 4'd7},
    '{1'b0, 2'd3, 13'h120, 64'h0, 64'h5555_6666_89AB_CDEF, 1'b0, 4'd7}, // R7
    '{1'b1, 2'd2, 13'h120, 64'h7777_8888, 64'h0, 1'b0, 4'd7},
    '{1'b0, 2'd3, 13'h120, 64'h0, 64'h5555_6666_7777_8888, 1'b0, 4'd7},
    '{1'b1, 2'd2, 13'h108, 64'h5, 64'h0, 1'b1, 4'd11},                 // R11 bad size
    '{1'b0, 2'd0, 13'h110, 64'h0, 64'h0, 1'b1, 4'd11},
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h2, 1'b0, 4'd10},                 // R10 sticky bit1
    '{1'b1, 2'd2, 13'h128, 64'h2, 64'h0, 1'b0, 4'd10},
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h0, 1'b0, 4'd10},                 // R10 cleared
    '{1'b0, 2'd2, 13'h130, 64'h0, 64'h0, 1'b1, 4'd12},                 // R12 unmapped
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h2, 1'b0, 4'd12},
    '{1'b1, 2'd2, 13'h128, 64'hFFFF_FFFF, 64'h0, 1'b0, 4'd10},
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h0, 1'b0, 4'd10},
    '{1'b0, 2'd0, 13'h004, 64'h0, 64'h0, 1'b1, 4'd12},                 // R12 global
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h0, 1'b0, 4'd12},
    '{1'b0, 2'd2, 13'h280, 64'h0, 64'h0, 1'b1, 4'd1},                  // R1 beyond NCH
    '{1'b1, 2'd0, 13'h118, 64'h04, 64'h0, 1'b0, 4'd9},                 // R9 suspend
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h1, 1'b0, 4'd9},
    '{1'b0, 2'd0, 13'h118, 64'h0, 64'h04, 1'b0, 4'd8},                 // R8 readback
    '{1'b1, 2'd2, 13'h128, 64'h1, 64'h0, 1'b0, 4'd10},
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h0, 1'b0, 4'd10},
    '{1'b1, 2'd2, 13'h100, 64'hFFFF, 64'h0, 1'b1, 4'd11},              // R11 no effect
    '{1'b0, 2'd1, 13'h100, 64'h0, 64'h1234, 1'b0, 4'd11},
    '{1'b1, 2'd2, 13'h128, 64'h2, 64'h0, 1'b0, 4'd10},
    '{1'b0, 2'd2, 13'h128, 64'h0, 64'h0, 1'b0, 4'd10}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [1:0]        reqSize = '0;
  logic [AW-1:0]     reqAddr = '0;
  logic [63:0]       reqWdata = '0;
  logic              rspValid, rspErr;
  logic [63:0]       rspRdata;
  logic [NCH-1:0]    startPulse, appendPulse, resetPulse;
  logic [NCH-1:0]    chanBusy = '0;
  logic [NCH-1:0]    complValid = '0;
  logic [57:0]       complDescIdx = '0;

  int nChecks = 0;
  int nFail   = 0;

  logic [63:0]    gotRd;
  logic           gotErr, gotVal;
  logic [NCH-1:0] gotS, gotA, gotR;

  always #4 clk = ~clk;

  chan_reg_file #(.NCH(NCH), .ADDR_W(AW)) u_chan_reg_file (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .startPulse(startPulse), .appendPulse(appendPulse), .resetPulse(resetPulse),
    .chanBusy(chanBusy), .complValid(complValid), .complDescIdx(complDescIdx)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [63:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    gotRd = rspRdata; gotErr = rspErr; gotVal = rspValid;
    gotS = startPulse; gotA = appendPulse; gotR = resetPulse;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 reset rspValid", {63'h0, rspValid}, 64'h0);
    chk("R8 reset pulses", {52'h0, startPulse, appendPulse, resetPulse}, 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wd);
      chk($sformatf("R%0d vec%0d rspValid(R2)", VEC[i].req, i), {63'h0, gotVal}, 64'h1);
      chk($sformatf("R%0d vec%0d data", VEC[i].req, i), gotRd, VEC[i].exp);
      chk($sformatf("R%0d vec%0d err", VEC[i].req, i), {63'h0, gotErr}, {63'h0, VEC[i].err});
      chk($sformatf("R%0d vec%0d no pulse (R9)", VEC[i].req, i),
          {52'h0, gotS, gotA, gotR}, 64'h0);
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    chk("R2 idle rspValid", {63'h0, rspValid}, 64'h0);

    // R8 start on channel 2 (window 3, base 0x180)
    access(1'b1, 2'd0, 13'h198, 64'h01);
    chk("R8 start pulse", {60'h0, gotS}, 64'h4);
    chk("R8 start no append/reset", {56'h0, gotA, gotR}, 64'h0);
    chanBusy = 4'b0100;
    access(1'b0, 2'd3, 13'h188, 64'h0);
    chk("R4 R8 active busy status", gotRd, 64'h0);
    chanBusy = 4'b0000;
    access(1'b0, 2'd3, 13'h188, 64'h0);
    chk("R4 active idle status", gotRd, 64'h1);

    // R8 priority
    access(1'b1, 2'd0, 13'h198, 64'h03);
    chk("R8 start over append", {56'h0, gotS, gotA}, {56'h0, 4'b0100, 4'b0000});
    access(1'b1, 2'd0, 13'h198, 64'h22);
    chk("R8 append over reset", {52'h0, gotS, gotA, gotR}, {52'h0, 4'b0000, 4'b0100, 4'b0000});
    access(1'b1, 2'd0, 13'h198, 64'h20);
    chk("R8 reset pulse", {52'h0, gotS, gotA, gotR}, {52'h0, 4'b0000, 4'b0000, 4'b0100});
    chanBusy = 4'b0100;
    access(1'b0, 2'd3, 13'h188, 64'h0);
    chk("R8 reset halts", gotRd, 64'h3);
    access(1'b0, 2'd0, 13'h198, 64'h0);
    chk("R8 cmd readback", gotRd, 64'h20);

    // R5 completed-descriptor capture
    @(negedge clk);
    complValid = 4'b0100; complDescIdx = 58'h0_1234_5678_9ABC;
    @(negedge clk);
    complValid = '0; complDescIdx = '0;
    access(1'b0, 2'd3, 13'h188, 64'h0);
    chk("R5 desc index in status", gotRd, {58'h0_1234_5678_9ABC, 6'd3});
    access(1'b0, 2'd3, 13'h108, 64'h0);
    chk("R5 other channel untouched", gotRd, 64'h3);

    finish_run();
  end
endmodule